// File: doc/BRIEF.md
# Readout Buffer Busy and Handshake Controller

This block fronts one readout buffer in a front-end crate. Event words from the digitiser side go into a first-in, first-out store. A downstream collector asks for data by raising a request. The block answers with a read enable, but only after a fixed holdoff has passed and only if the buffer is below its half-full mark at that moment. Once the enable is up, one word leaves the buffer on each cycle unless the collector holds its wait line high. The enable falls one cycle after the request goes away.

The block drives a busy line back to the trigger system. Busy is always raised when the store is completely full. A configuration input adds the half-full flag to busy, so that triggers can be blocked across the whole system before this buffer drops data. A write that arrives while the store is full is discarded and sets a sticky overflow flag. A four-bit status word shows the flags and the configuration bit.

Top module: `rob_ctrl`

## Requirements
- R1: Words leave the store in the order they were written. A word is removed on a clock edge only when the read enable is high and wait is low. It appears on the read data output with the read-valid flag one cycle later.
- R2: The half-full flag is high exactly when the occupancy is at or above HF_MARK words.
- R3: The full flag is high when the occupancy equals DEPTH. Busy is high whenever the store is full, whatever the configuration bit.
- R4: A write while the store is full is dropped and does not displace any stored word. The overflow flag then stays high until reset.
- R5: When the configuration bit is set, busy also follows the half-full flag. When the bit is clear, half-full alone does not raise busy.
- R6: The read enable rises on the HOLDOFF+1-th clock edge at which the request is sampled high, counting from the first such edge.
- R7: If the request drops before the holdoff has elapsed, the holdoff count starts again from zero on the next request.
- R8: The read enable is low on the first clock edge after the request is sampled low.
- R9: The read enable never rises while the half-full flag is set, regardless of the busy configuration. Once high, it stays high while the request stays high.
- R10: While wait is high, no word leaves the store and read-valid stays low.
- R11: After reset the store is empty and the enable, busy, and all flags are low. The status word holds half-full in bit 0, full in bit 1, the busy-or configuration in bit 2 and overflow in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one event word |
| wr_data_i | input | DATA_W | Event word to store |
| req_i | input | 1 | Downstream data request |
| wait_i | input | 1 | Downstream stall |
| hf_busy_en_i | input | 1 | Adds half-full to busy when set |
| ren_o | output | 1 | Read enable to the collector |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | DATA_W | Word leaving the store |
| busy_o | output | 1 | Busy to the trigger logic |
| status_o | output | 4 | {overflow, busy-or enable, full, half-full} |

## Verification
The bench builds the block with DEPTH 16, HF_MARK 8 and HOLDOFF 4, instead of 4096, 2048 and 800. This makes the full, half-full and overflow boundaries reachable in a few dozen writes. It also makes the holdoff edge count short enough to check each cycle on both sides of the edge where the enable rises. With these sizes, the bench can fill the store past full while the enable is already high and wait blocks reads, and then drain it. This shows that the dropped word never comes out and that order is kept. It can also show that a half-full store never raises the enable when the busy configuration is clear.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned STAT_W   = 4;
  localparam int unsigned ST_HF    = 0;
  localparam int unsigned ST_FULL  = 1;
  localparam int unsigned ST_HFBSY = 2;
  localparam int unsigned ST_OVF   = 3;
endpackage

// File: rtl/rob_fifo.sv
module rob_fifo #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 4096,
  parameter int unsigned HF_MARK = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hf_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic              do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign hf_o    = (count_q >= CW'(HF_MARK));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      count_q    <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      ovf_o      <= 1'b0;
    end else begin
      rd_valid_o <= do_pop;
      if (do_pop) begin
        rd_data_o <= mem_q[rd_ptr_q];
        rd_ptr_q  <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
      if (do_push)
        wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end

  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r4_full_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/rob_holdoff.sv
module rob_holdoff #(
  parameter int unsigned HOLDOFF = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic done_o
);
  localparam int unsigned TW = $clog2(HOLDOFF + 1);

  logic [TW-1:0] cnt_q;

  assign done_o = (cnt_q == TW'(HOLDOFF));

  // restarts from zero whenever the request drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!req_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r7_clear_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (cnt_q == '0));
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 4096,
  parameter int unsigned HF_MARK = DEPTH / 2,
  parameter int unsigned HOLDOFF = 800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              req_i,
  input  logic              wait_i,
  input  logic              hf_busy_en_i,
  output logic              ren_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic [STAT_W-1:0] status_o
);
  logic hf, full, empty, ovf, hold_done, ren_q;

  rob_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .HF_MARK(HF_MARK)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_en_i),
    .push_data_i(wr_data_i),
    .pop_i      (ren_q && !wait_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .hf_o       (hf),
    .full_o     (full),
    .empty_o    (empty),
    .ovf_o      (ovf)
  );

  rob_holdoff #(.HOLDOFF(HOLDOFF)) i_holdoff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .done_o(hold_done)
  );

  // enable is granted only from a below-half-full state, then held with req
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ren_q <= 1'b0;
    else         ren_q <= req_i && (ren_q || (hold_done && !hf));
  end

  assign ren_o  = ren_q;
  assign busy_o = full || (hf_busy_en_i && hf);

  always_comb begin
    status_o           = '0;
    status_o[ST_HF]    = hf;
    status_o[ST_FULL]  = full;
    status_o[ST_HFBSY] = hf_busy_en_i;
    status_o[ST_OVF]   = ovf;
  end

  a_r9_no_rise_hf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ren_o) |-> !$past(hf));
  a_r8_drop_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ren_o);
  a_r3_full_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> busy_o);
  a_r10_wait_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |=> !rd_valid_o);
  a_r1_valid_needs_ren: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(ren_o) && !empty || $past(ren_o));
endmodule

// File: tb/test_rob_ctrl.sv
module test_rob_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int HFM = 8;
  localparam int HOLD = 4;

  typedef struct packed {
    int nwr; bit en; bit hf; bit full; bit busy;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{3,  1'b0, 1'b0, 1'b0, 1'b0},
    '{8,  1'b0, 1'b1, 1'b0, 1'b0},
    '{8,  1'b1, 1'b1, 1'b0, 1'b1},
    '{16, 1'b0, 1'b1, 1'b1, 1'b1},
    '{7,  1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, req = 1'b0, wt = 1'b0, hfen = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic ren, rd_valid, busy;
  logic [DW-1:0] rd_data;
  logic [3:0] status;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .HF_MARK(HFM), .HOLDOFF(HOLD)) i_rob_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .req_i(req), .wait_i(wt), .hf_busy_en_i(hfen), .ren_o(ren),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy), .status_o(status));

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 0; req = 0; wt = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic write_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = DW'(base + i);
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R11 reset state
    hfen = 1;
    do_reset();
    chk("R11 ren", ren, 0);
    chk("R11 busy", busy, 0);
    chk("R11 rd_valid", rd_valid, 0);
    chk("R11 status", status, 4'b0100);

    // table walk: R2 R3 R5
    for (int v = 0; v < 5; v++) begin
      hfen = VEC[v].en;
      do_reset();
      write_n(VEC[v].nwr, 0);
      chk("R2 hf", status[0], VEC[v].hf);
      chk("R3 full", status[1], VEC[v].full);
      chk("R5 busy", busy, VEC[v].busy);
    end

    // R6 holdoff timing and R1 order
    hfen = 0;
    do_reset();
    write_n(3, 'hA0);
    wt = 1; req = 1;
    ticks(HOLD);
    chk("R6 ren before holdoff", ren, 0);
    ticks(1);
    chk("R6 ren after holdoff", ren, 1);
    ticks(2);
    chk("R10 no valid while wait", rd_valid, 0);
    wt = 0;
    for (int i = 0; i < 3; i++) begin
      ticks(1);
      chk("R1 valid", rd_valid, 1);
      chk("R1 order", rd_data, DW'('hA0 + i));
    end
    ticks(1);
    chk("R1 empty no valid", rd_valid, 0);

    // R8 drop
    req = 0;
    ticks(1);
    chk("R8 ren drops", ren, 0);

    // R7 restart
    req = 1; ticks(HOLD - 1);
    req = 0; ticks(1);
    req = 1; ticks(HOLD);
    chk("R7 no ren after restart", ren, 0);
    ticks(1);
    chk("R7 ren after full holdoff", ren, 1);
    req = 0; ticks(1);

    // R9 half full blocks enable, busy config clear
    do_reset();
    hfen = 0;
    write_n(HFM, 0);
    wt = 1; req = 1;
    ticks(HOLD + 4);
    chk("R9 ren blocked by hf", ren, 0);
    chk("R9 busy clear with cfg off", busy, 0);
    req = 0; wt = 0;

    // R4 overflow with enable held and wait blocking
    do_reset();
    wt = 1; req = 1;
    ticks(HOLD + 1);
    chk("R4 ren up before fill", ren, 1);
    write_n(DEPTH + 1, 'h100);
    chk("R4 overflow set", status[3], 1);
    chk("R3 full busy", busy, 1);
    chk("R9 ren held while hf", ren, 1);
    wt = 0;
    for (int i = 0; i < DEPTH; i++) begin
      ticks(1);
      chk("R4 drained word", rd_data, DW'('h100 + i));
    end
    ticks(1);
    chk("R4 dropped word absent", rd_valid, 0);
    chk("R4 overflow sticky", status[3], 1);
    req = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule